// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block is the 8-bit interrupt request register that sits between a small controller's peripherals and its interrupt logic. Each implemented bit records one kind of peripheral event: a finished analogue conversion, receive-buffer occupancy, transmit-buffer vacancy, a synchronous serial module event, a capture/compare event and two timer events. A peripheral asserts a one-cycle pulse. The matching flag is then set no matter how the enables are configured, so software can poll the register with interrupts masked.

Two kinds of flag live side by side. Five flags are sticky. Hardware sets them, and software clears them by writing 0. Software may also write 1 to raise one on purpose. The receive and transmit flags are read-only mirrors of buffer state. They change only through side effects: a read of the receive data register empties the receive buffer, and a write of the transmit data register fills the transmit buffer. One request line combines all flags with a per-bit enable mask, a peripheral-group enable and a global enable.

Top module: `periph_irq_flags`

## Requirements
- R1: The register is 8 bits wide. From bit 7 down to bit 0 it holds: unused, conversion done, receive full, transmit empty, serial module event, capture/compare, timer-2 match, timer-1 overflow. Bit 7 always reads 0, and writes to it are ignored.
- R2: After reset every flag reads 0 and `irq_req` is 0.
- R3: An event pulse on `adc_done`, `tmr2_match` or `tmr1_ovf` sets its sticky flag (bits 6, 1, 0) at the next clock edge. This happens whatever the values of `irq_en`, `peie` and `gie`. The flag then stays 1 with no further events.
- R4: A register write loads bits 6, 3, 2, 1 and 0 from `wr_data`. Writing 0 clears a sticky flag and writing 1 sets it.
- R5: When a hardware event and a software write of 0 hit the same sticky flag in the same cycle, the flag ends up 1.
- R6: Bit 5 becomes 1 on `rx_load` and becomes 0 on `rx_read`. If both occur in the same cycle it stays 1. Register writes do not change it.
- R7: Bit 4 becomes 1 on `tx_drain` and becomes 0 on `tx_write`. If both occur in the same cycle it becomes 0. Register writes do not change it.
- R8: `ccp_mode` encodes 0 = capture, 1 = compare, 2 = PWM, 3 = off. Bit 2 is set by `ccp_capture` only in mode 0 and by `ccp_match` only in mode 1. It is never set by events in modes 2 or 3.
- R9: A pulse on any one of the `ssp_evt` source lines sets bit 3. The lines are: transfer done, start done, stop done, repeated start done, acknowledge done, bus start seen while idle, bus stop seen while idle.
- R10: `irq_req` equals `gie` AND `peie` AND the OR over bits 6..0 of (flag AND `irq_en`), in the same cycle as the flags. `irq_en[7]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| adc_done | input | 1 | Conversion complete pulse |
| ssp_evt | input | 7 | Serial module event sources, one pulse line each |
| ccp_mode | input | 2 | Capture/compare unit mode |
| ccp_capture | input | 1 | Capture event pulse |
| ccp_match | input | 1 | Compare match pulse |
| tmr2_match | input | 1 | Timer-2 period match pulse |
| tmr1_ovf | input | 1 | Timer-1 overflow pulse |
| rx_load | input | 1 | Receive buffer gets a byte |
| rx_read | input | 1 | Receive data register read |
| tx_drain | input | 1 | Transmit buffer handed to the shifter |
| tx_write | input | 1 | Transmit data register written |
| irq_en | input | 8 | Per-bit interrupt enables |
| peie | input | 1 | Peripheral group enable |
| gie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled on the rising edge. They also assume that `ccp_mode` is held at a legal 2-bit code and that reset is synchronous. The bench drives every input on the falling edge and returns each pulse to 0 after one edge. It draws `ccp_mode` over all four codes, with events sparse enough that flags are seen both rising and being cleared. Write strobes, buffer side effects and enable combinations are randomized independently, so collisions such as a set against a clear, or a load against a read, occur naturally as well as in directed cases.

// File: rtl/periph_irq_pkg.sv
package periph_irq_pkg;
   localparam int REG_W   = 8;
   localparam int SSP_SRC = 7;

   localparam int B_ADC  = 6;
   localparam int B_RX   = 5;
   localparam int B_TX   = 4;
   localparam int B_SSP  = 3;
   localparam int B_CCP  = 2;
   localparam int B_TMR2 = 1;
   localparam int B_TMR1 = 0;

   localparam logic [REG_W-1:0] STICKY_MASK = 8'h4F;

   typedef enum logic [1:0] {
      CCP_CAPTURE = 2'd0,
      CCP_COMPARE = 2'd1,
      CCP_PWM     = 2'd2,
      CCP_OFF     = 2'd3
   } ccp_mode_e;
endpackage

// File: rtl/pif_sticky_bit.sv
module pif_sticky_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic we_i,
   input  logic wd_i,
   output logic q_o
);
   logic d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb d = set_i | (we_i ? wd_i : q_o);

         p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
      end else begin : g_write_first
         always_comb d = we_i ? wd_i : (q_o | set_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= d;
   end

   p_holds_until_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !we_i) |=> $stable(q_o));
endmodule

// File: rtl/pif_status_bit.sv
module pif_status_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb d = set_i | (q_o & ~clr_i);
      end else begin : g_clr_first
         always_comb d = (set_i | q_o) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= d;
   end

   p_clear_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   p_set_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> q_o);
endmodule

// File: rtl/pif_event_route.sv
module pif_event_route
   import periph_irq_pkg::*;
#(
   parameter int N_SRC = SSP_SRC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] ssp_evt_i,
   input  logic [1:0]       ccp_mode_i,
   input  logic             ccp_capture_i,
   input  logic             ccp_match_i,
   output logic             ssp_set_o,
   output logic             ccp_set_o
);
   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("pif_event_route: N_SRC must be at least 1");
      end
   endgenerate

   ccp_mode_e mode;
   always_comb mode = ccp_mode_e'(ccp_mode_i);

   always_comb ssp_set_o = |ssp_evt_i;

   always_comb begin
      unique case (mode)
         CCP_CAPTURE: ccp_set_o = ccp_capture_i;
         CCP_COMPARE: ccp_set_o = ccp_match_i;
         default:     ccp_set_o = 1'b0;
      endcase
   end

   p_pwm_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ccp_mode_i == 2'd2) |-> !ccp_set_o);
   p_any_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ssp_evt_i != '0) |-> ssp_set_o);
endmodule

// File: rtl/periph_irq_flags.sv
module periph_irq_flags
   import periph_irq_pkg::*;
#(
   parameter int W        = REG_W,
   parameter int N_SSP    = SSP_SRC,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   output logic [W-1:0]     rd_data,
   input  logic             adc_done,
   input  logic [N_SSP-1:0] ssp_evt,
   input  logic [1:0]       ccp_mode,
   input  logic             ccp_capture,
   input  logic             ccp_match,
   input  logic             tmr2_match,
   input  logic             tmr1_ovf,
   input  logic             rx_load,
   input  logic             rx_read,
   input  logic             tx_drain,
   input  logic             tx_write,
   input  logic [W-1:0]     irq_en,
   input  logic             peie,
   input  logic             gie,
   output logic             irq_req
);
   generate
      if (W != REG_W) begin : g_bad_width
         $error("periph_irq_flags: W must equal the fixed register width");
      end
   endgenerate

   logic         ssp_set, ccp_set;
   logic [W-1:0] hw_set;
   logic [W-1:0] flags;

   pif_event_route #(.N_SRC(N_SSP)) route_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .ssp_evt_i     (ssp_evt),
      .ccp_mode_i    (ccp_mode),
      .ccp_capture_i (ccp_capture),
      .ccp_match_i   (ccp_match),
      .ssp_set_o     (ssp_set),
      .ccp_set_o     (ccp_set)
   );

   always_comb begin
      hw_set         = '0;
      hw_set[B_ADC]  = adc_done;
      hw_set[B_SSP]  = ssp_set;
      hw_set[B_CCP]  = ccp_set;
      hw_set[B_TMR2] = tmr2_match;
      hw_set[B_TMR1] = tmr1_ovf;
   end

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         if (STICKY_MASK[i]) begin : g_sticky
            pif_sticky_bit #(.SET_WINS(SET_WINS)) bit_i (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (hw_set[i]),
               .we_i  (wr_en),
               .wd_i  (wr_data[i]),
               .q_o   (flags[i])
            );
         end else if (i == B_RX) begin : g_rx
            pif_status_bit #(.SET_WINS(1'b1)) bit_i (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (rx_load),
               .clr_i (rx_read),
               .q_o   (flags[i])
            );
         end else if (i == B_TX) begin : g_tx
            pif_status_bit #(.SET_WINS(1'b0)) bit_i (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (tx_drain),
               .clr_i (tx_write),
               .q_o   (flags[i])
            );
         end else begin : g_unused
            assign flags[i] = 1'b0;
         end
      end
   endgenerate

   assign rd_data = flags;
   assign irq_req = gie & peie & (|(flags & irq_en));

   p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr1_ovf || adc_done) |=> (rd_data[B_TMR1] || rd_data[B_ADC]));
   p_write_ignored_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rx_load && !rx_read) |=> $stable(rd_data[B_RX]));
   p_tx_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_write |=> !rd_data[B_TX]);
   p_no_request_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq_req);
   p_top_bit_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rd_data[W-1]);
endmodule

// File: tb/periph_irq_flags_tb_top.sv
module periph_irq_flags_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       adc_done;
   logic [6:0] ssp_evt;
   logic [1:0] ccp_mode;
   logic       ccp_capture, ccp_match, tmr2_match, tmr1_ovf;
   logic       rx_load, rx_read, tx_drain, tx_write;
   logic [7:0] irq_en;
   logic       peie, gie, irq_req;

   int   n_chk = 0;
   int   n_bad = 0;
   logic [7:0] model;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   periph_irq_flags dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .adc_done(adc_done), .ssp_evt(ssp_evt), .ccp_mode(ccp_mode),
      .ccp_capture(ccp_capture), .ccp_match(ccp_match), .tmr2_match(tmr2_match),
      .tmr1_ovf(tmr1_ovf), .rx_load(rx_load), .rx_read(rx_read), .tx_drain(tx_drain),
      .tx_write(tx_write), .irq_en(irq_en), .peie(peie), .gie(gie), .irq_req(irq_req)
   );

   function automatic logic [7:0] next_model(logic [7:0] m);
      logic [7:0] s, n;
      s = '0;
      s[6] = adc_done;
      s[3] = |ssp_evt;
      s[2] = (ccp_mode == 2'd0 && ccp_capture) || (ccp_mode == 2'd1 && ccp_match);
      s[1] = tmr2_match;
      s[0] = tmr1_ovf;
      n = (s | (wr_en ? wr_data : m)) & 8'h4F;
      n[5] = rx_load | (m[5] & ~rx_read);
      n[4] = (tx_drain | m[4]) & ~tx_write;
      return n;
   endfunction

   function automatic logic exp_irq(logic [7:0] m);
      return gie & peie & (|(m & irq_en & 8'h7F));
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 0; wr_data = 0; adc_done = 0; ssp_evt = 0;
      ccp_capture = 0; ccp_match = 0; tmr2_match = 0; tmr1_ovf = 0;
      rx_load = 0; rx_read = 0; tx_drain = 0; tx_write = 0;
   endtask

   // inputs are already set (after a falling edge); advance one edge and update model
   task automatic step();
      logic [7:0] nxt;
      nxt = next_model(model);
      @(posedge clk);
      #1;
      model = nxt;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic check_all(string req);
      chk(req, rd_data, model);
      chk(req, {7'd0, irq_req}, {7'd0, exp_irq(model)});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      idle_inputs();
      ccp_mode = 2'd0; irq_en = 8'hFF; peie = 1; gie = 1;
      rst_n = 0;
      model = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R2: reset state
      chk("R2 flags", rd_data, 8'h00);
      chk("R2 irq", {7'd0, irq_req}, 8'h00);

      // R1: bit 7 write ignored, reads 0
      wr_en = 1; wr_data = 8'h80; step();
      chk("R1 bit7", rd_data, 8'h00);

      // R3: events set flags with every enable off, and stay set
      irq_en = 0; peie = 0; gie = 0;
      adc_done = 1; tmr2_match = 1; tmr1_ovf = 1; step();
      chk("R3 set", rd_data, 8'h43);
      chk("R10 masked", {7'd0, irq_req}, 8'h00);
      step(); step();
      chk("R3 hold", rd_data, 8'h43);

      // R10: enables
      irq_en = 8'h02; gie = 1; peie = 0; #1;
      chk("R10 peie off", {7'd0, irq_req}, 8'h00);
      peie = 1; #1;
      chk("R10 on", {7'd0, irq_req}, 8'h01);
      irq_en = 8'h80; #1;
      chk("R10 bit7 en", {7'd0, irq_req}, 8'h00);
      irq_en = 8'hFF;

      // R4: write 0 clears, write 1 sets
      wr_en = 1; wr_data = 8'h00; step();
      chk("R4 clear", rd_data, 8'h00);
      wr_en = 1; wr_data = 8'hFF; step();
      chk("R4 force", rd_data, 8'h4F);
      chk("R10 forced irq", {7'd0, irq_req}, 8'h01);
      wr_en = 1; wr_data = 8'h00; step();

      // R5: set beats clear
      wr_en = 1; wr_data = 8'h00; tmr1_ovf = 1; adc_done = 1; step();
      chk("R5 collide", rd_data, 8'h41);
      wr_en = 1; wr_data = 8'h00; step();

      // R6: receive status
      rx_load = 1; step();
      chk("R6 load", rd_data, 8'h20);
      wr_en = 1; wr_data = 8'h00; step();
      chk("R6 write ignored", rd_data, 8'h20);
      rx_load = 1; rx_read = 1; step();
      chk("R6 load+read", rd_data, 8'h20);
      rx_read = 1; step();
      chk("R6 read", rd_data, 8'h00);
      wr_en = 1; wr_data = 8'h20; step();
      chk("R6 write1 ignored", rd_data, 8'h00);

      // R7: transmit status
      tx_drain = 1; step();
      chk("R7 drain", rd_data, 8'h10);
      wr_en = 1; wr_data = 8'h00; step();
      chk("R7 write ignored", rd_data, 8'h10);
      tx_drain = 1; tx_write = 1; step();
      chk("R7 drain+write", rd_data, 8'h00);

      // R8: capture/compare mode selection
      for (int md = 0; md < 4; md++) begin
         ccp_mode = md[1:0]; ccp_capture = 1; step();
         chk($sformatf("R8 capture mode %0d", md), rd_data, (md == 0) ? 8'h04 : 8'h00);
         wr_en = 1; wr_data = 0; step();
         ccp_mode = md[1:0]; ccp_match = 1; step();
         chk($sformatf("R8 match mode %0d", md), rd_data, (md == 1) ? 8'h04 : 8'h00);
         wr_en = 1; wr_data = 0; step();
      end

      // R9: each serial source alone
      for (int k = 0; k < 7; k++) begin
         ssp_evt = 7'(1 << k); step();
         chk($sformatf("R9 source %0d", k), rd_data, 8'h08);
         wr_en = 1; wr_data = 0; step();
      end

      // random phase against the bench model
      for (int c = 0; c < 3000; c++) begin
         wr_en       = ($urandom_range(0, 7) == 0);
         wr_data     = 8'($urandom);
         adc_done    = ($urandom_range(0, 9) == 0);
         ssp_evt     = ($urandom_range(0, 9) == 0) ? 7'($urandom) : 7'd0;
         ccp_mode    = 2'($urandom);
         ccp_capture = ($urandom_range(0, 5) == 0);
         ccp_match   = ($urandom_range(0, 5) == 0);
         tmr2_match  = ($urandom_range(0, 9) == 0);
         tmr1_ovf    = ($urandom_range(0, 9) == 0);
         rx_load     = ($urandom_range(0, 4) == 0);
         rx_read     = ($urandom_range(0, 4) == 0);
         tx_drain    = ($urandom_range(0, 4) == 0);
         tx_write    = ($urandom_range(0, 4) == 0);
         irq_en      = 8'($urandom);
         peie        = 1'($urandom);
         gie         = 1'($urandom);
         step();
         check_all("R1 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule